// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst memory. When either of two active-low address strobes is asserted at a rising clock edge, it registers the full address, the burst ordering mode and the three chip-enable inputs. One strobe serves a processor and the other a cache controller. From the registered start address it produces a burst of four addresses. The upper address bits stay fixed. A 2-bit beat counter steps the two lowest bits, and it advances only on cycles where the active-low advance input is asserted and the device is selected.

The ordering input picks between two burst orders. In interleaved order the low bits are the start value XOR the beat count. In linear order the low bits are the start value plus the beat count, modulo four, so the burst wraps inside its aligned group of four. A strobe that arrives during a burst drops that burst and loads a new start address. The output address is derived from registered state without further delay. A memory array can therefore use it in the cycle after the strobe, which gives an initial access followed by three single-cycle beats.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low and after its release with no strobe seen, addr_o is 0, sel_o is 0 and last_o is 0.
- R2: When ads_proc_n_i is 0 at a rising edge, addr_o equals the addr_i sampled at that edge from the next cycle on.
- R3: When ads_ctrl_n_i is 0 at a rising edge, the same load takes place even if ads_proc_n_i is 1.
- R4: With mode_i = 1 captured at the load, addr_o[1:0] = start[1:0] XOR beat, where beat is the number of advances since the load, modulo 4 (start 2 gives 2,3,0,1).
- R5: With mode_i = 0 captured at the load, addr_o[1:0] = (start[1:0] + beat) mod 4 (start 1 gives 1,2,3,0).
- R6: A cycle with both strobes at 1 and adv_n_i at 1 leaves addr_o unchanged.
- R7: Between loads, addr_o bits above bit 1 keep the value captured at the load.
- R8: A strobe during a burst abandons it: the new address appears unchanged and the beat count restarts at 0.
- R9: sel_o is 1 only if the load captured en_a_n_i = 0, en_b_i = 1 and en_c_n_i = 0. While sel_o is 0, adv_n_i has no effect on addr_o.
- R10: last_o is 1 exactly when the beat count is 3. One more advance wraps the beat count to 0, which gives back the start address.
- R11: mode_i is used only at a load. Changing it mid-burst does not alter the burst order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| en_a_n_i | input | 1 | Chip enable, active low |
| en_b_i | input | 1 | Depth-expansion enable, active high |
| en_c_n_i | input | 1 | Depth-expansion enable, active low |
| addr_i | input | ADDR_W | Start address |
| addr_o | output | ADDR_W | Current memory address |
| sel_o | output | 1 | Device selected for the current burst |
| last_o | output | 1 | Fourth beat of the burst |

## Verification
The bench builds the block with ADDR_W = 10 and BURST_W = 2. At this width the upper address field is small enough to hold distinct patterns, including all ones, so a leak from the low counter into the upper bits shows up as a changed address. BURST_W = 2 gives the four-beat burst. At this setting every start offset in both orders, the wrap after the fourth beat and a restart mid-burst can all be reached in a short run.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic en_a_n;
    logic en_b;
    logic en_c_n;
  } enables_t;

  function automatic logic enables_ok(enables_t e);
    return !e.en_a_n && e.en_b && !e.en_c_n;
  endfunction
endpackage

// File: rtl/bseq_strobe_decode.sv
module bseq_strobe_decode (
  input  logic ads_proc_n_i,
  input  logic ads_ctrl_n_i,
  input  logic adv_n_i,
  input  logic sel_i,
  output logic load_o,
  output logic step_o
);
  // Either strobe loads; a load wins over an advance.
  always_comb begin
    load_o = !ads_proc_n_i || !ads_ctrl_n_i;
    step_o = !load_o && !adv_n_i && sel_i;
  end
endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  input  enables_t          en_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            order_o,
  output logic              sel_o
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] start_q;
  order_e             order_q;
  logic               sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      order_q <= ORD_LINEAR;
      sel_q   <= 1'b0;
    end else if (load_i) begin
      start_q <= addr_i[BURST_W-1:0];
      order_q <= order_e'(mode_i);
      sel_q   <= enables_ok(en_i);
    end
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      logic [UPPER_W-1:0] upper_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     upper_q <= '0;
        else if (load_i) upper_q <= addr_i[ADDR_W-1:BURST_W];
      end
      assign base_o = {upper_q, start_q};
    end else begin : g_flat
      assign base_o = start_q;
    end
  endgenerate

  assign order_o = order_q;
  assign sel_o   = sel_q;

  // R11: captured order only changes at a load
  p_order_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(order_q));
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] beat_o,
  output logic               last_o
);
  localparam logic [BURST_W-1:0] LAST_BEAT = {BURST_W{1'b1}};

  logic [BURST_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (load_i)  beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + BURST_W'(1);
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == LAST_BEAT);

  // R8: a load always restarts the burst
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (beat_q == '0) && !last_o);
  // R10: advancing past the last beat wraps to the first
  p_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o) |=> (beat_q == '0));
  // R6: no load and no step keeps the beat
  p_beat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(beat_q));
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  input  order_e             order_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] ilv_low;

  // Linear wraps inside the aligned group; interleave toggles bits.
  always_comb begin
    lin_low = start_i + beat_i;
    ilv_low = start_i ^ beat_i;
    low_o   = (order_i == ORD_INTERLEAVE) ? ilv_low : lin_low;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_proc_n_i,
  input  logic              ads_ctrl_n_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  input  logic              en_a_n_i,
  input  logic              en_b_i,
  input  logic              en_c_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              last_o
);
  logic               load;
  logic               step;
  logic [ADDR_W-1:0]  base;
  order_e             order;
  logic               sel;
  logic [BURST_W-1:0] beat;
  logic [BURST_W-1:0] low;
  enables_t           en;

  assign en = '{en_a_n: en_a_n_i, en_b: en_b_i, en_c_n: en_c_n_i};

  bseq_strobe_decode u_dec (
    .ads_proc_n_i (ads_proc_n_i),
    .ads_ctrl_n_i (ads_ctrl_n_i),
    .adv_n_i      (adv_n_i),
    .sel_i        (sel),
    .load_o       (load),
    .step_o       (step)
  );

  bseq_capture #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .en_i    (en),
    .base_o  (base),
    .order_o (order),
    .sel_o   (sel)
  );

  bseq_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .beat_o (beat),
    .last_o (last_o)
  );

  bseq_order #(.BURST_W(BURST_W)) u_ord (
    .start_i (base[BURST_W-1:0]),
    .beat_i  (beat),
    .order_i (order),
    .low_o   (low)
  );

  generate
    if (ADDR_W > BURST_W) begin : g_cat
      assign addr_o = {base[ADDR_W-1:BURST_W], low};
    end else begin : g_low
      assign addr_o = low;
    end
  endgenerate
  assign sel_o = sel;

  // R2: processor strobe loads the address
  p_load_proc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_proc_n_i |=> addr_o == $past(addr_i));
  // R3: controller strobe alone loads the address
  p_load_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_n_i && !ads_ctrl_n_i) |=> addr_o == $past(addr_i));
  // R6: idle cycle holds the address
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_n_i && ads_ctrl_n_i && adv_n_i) |=> $stable(addr_o));
  // R7: upper bits fixed between loads
  p_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_n_i && ads_ctrl_n_i) |=> $stable(addr_o[ADDR_W-1:BURST_W]));
  // R9: a deselected burst ignores advance
  p_desel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_proc_n_i && ads_ctrl_n_i && !sel_o) |=> $stable(addr_o) && !sel_o);
endmodule

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 10;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ps_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
  logic          ea_n = 1'b0, eb = 1'b1, ec_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] addr_o;
  logic          sel_o, last_o;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ads_proc_n_i(ps_n), .ads_ctrl_n_i(cs_n),
    .adv_n_i(adv_n), .mode_i(mode), .en_a_n_i(ea_n), .en_b_i(eb),
    .en_c_n_i(ec_n), .addr_i(addr), .addr_o(addr_o), .sel_o(sel_o),
    .last_o(last_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          sel;
    logic          last;
    string         req;
  } exp_t;

  exp_t queue_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // Bench model state
  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_beat = '0;
  logic          m_mode = 1'b0;
  logic          m_sel  = 1'b0;

  function automatic logic [AW-1:0] model_addr();
    logic [BW-1:0] lo;
    lo = m_mode ? (m_base[BW-1:0] ^ m_beat) : (m_base[BW-1:0] + m_beat);
    return {m_base[AW-1:BW], lo};
  endfunction

  task automatic check(logic [AW-1:0] ea, logic es, logic el, string req);
    vectors++;
    if (addr_o !== ea || sel_o !== es || last_o !== el) begin
      miscompares++;
      $display("FAIL %s: addr=%h sel=%b last=%b expected addr=%h sel=%b last=%b",
               req, addr_o, sel_o, last_o, ea, es, el);
    end
  endtask

  // Driver: applies one cycle of inputs at the falling edge, pushes the model result.
  task automatic step(logic p, logic c, logic a, logic md, logic [AW-1:0] ad,
                      logic ena_n, logic enb, logic enc_n, string req);
    exp_t e;
    @(negedge clk);
    ps_n = p; cs_n = c; adv_n = a; mode = md; addr = ad;
    ea_n = ena_n; eb = enb; ec_n = enc_n;
    if (!p || !c) begin
      m_base = ad; m_beat = '0; m_mode = md;
      m_sel  = !ena_n && enb && !enc_n;
    end else if (!a && m_sel) begin
      m_beat = m_beat + 2'd1;
    end
    e.addr = model_addr(); e.sel = m_sel; e.last = (m_beat == 2'd3); e.req = req;
    queue_q.push_back(e);
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (queue_q.size() > 0) begin
      exp_t e;
      e = queue_q.pop_front();
      check(e.addr, e.sel, e.last, e.req);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #20000;
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check('0, 1'b0, 1'b0, "R1 in reset");
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check('0, 1'b0, 1'b0, "R1 after release");

    // R2 + R4: processor strobe, interleaved, start 2 -> 2,3,0,1
    step(0, 1, 1, 1, 10'h2A6, 0, 1, 0, "R2 proc load");
    step(1, 1, 0, 1, 10'h000, 0, 1, 0, "R4 interleave beat1");
    step(1, 1, 0, 1, 10'h000, 0, 1, 0, "R4 interleave beat2");
    step(1, 1, 0, 1, 10'h000, 0, 1, 0, "R10 last beat");
    step(1, 1, 0, 1, 10'h000, 0, 1, 0, "R10 wrap to start");

    // R3 + R5: controller strobe, linear, start 1 -> 1,2,3,0; mode flip mid-burst
    step(1, 0, 1, 0, 10'h3FD, 0, 1, 0, "R3 ctrl load");
    step(1, 1, 0, 0, 10'h155, 0, 1, 0, "R5 linear beat1");
    step(1, 1, 1, 1, 10'h0AA, 0, 1, 0, "R6 hold with adv high");
    step(1, 1, 0, 1, 10'h000, 0, 1, 0, "R11 mode flip ignored");
    step(1, 1, 0, 1, 10'h2AA, 0, 1, 0, "R7 upper bits kept");

    // R4 interleave start 3 -> 3,2,1,0
    step(0, 0, 0, 1, 10'h1C7, 0, 1, 0, "R2 both strobes load");
    step(1, 1, 0, 0, 10'h000, 0, 1, 0, "R4 interleave start3 beat1");
    step(1, 1, 0, 0, 10'h000, 0, 1, 0, "R4 interleave start3 beat2");

    // R8: strobe mid-burst restarts
    step(1, 0, 0, 0, 10'h0F2, 0, 1, 0, "R8 restart load");
    step(1, 1, 0, 0, 10'h000, 0, 1, 0, "R8 linear after restart");
    step(1, 1, 0, 0, 10'h000, 0, 1, 0, "R5 linear wrap within group");

    // R9: deselected bursts ignore advance
    step(0, 1, 1, 0, 10'h111, 0, 0, 0, "R9 load deselected en_b");
    step(1, 1, 0, 0, 10'h000, 0, 0, 0, "R9 advance ignored");
    step(1, 0, 1, 1, 10'h222, 1, 1, 0, "R9 load deselected en_a");
    step(1, 1, 0, 1, 10'h000, 1, 1, 0, "R9 advance ignored again");
    step(0, 1, 1, 1, 10'h333, 0, 1, 1, "R9 load deselected en_c");
    step(1, 0, 1, 0, 10'h040, 0, 1, 0, "R9 reselect");
    step(1, 1, 0, 0, 10'h000, 0, 1, 0, "R5 linear start0 beat1");
    step(1, 1, 1, 0, 10'h000, 0, 1, 0, "R6 hold idle");

    repeat (3) @(posedge clk);
    #2 finish_run();
  end
endmodule